// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block pairs a synchronous two-port word memory with a pair of cross-port interrupt flags. Each port owns one reserved word at the top of the address space as its incoming mailbox. Port A's mailbox is the next-to-last word and port B's mailbox is the last word. When one port writes into its partner's mailbox, an active-low interrupt output toward that partner goes low. The partner acknowledges by reading its own mailbox, which releases the interrupt. A 16-bit message can travel with the notification in a single access.

The mailbox words stay ordinary storage. Code that never watches the interrupt outputs can use them like any other location. The address width is a parameter, so simulations can shrink the array while keeping the mailboxes at the top two words.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, both `a_irq_n` and `b_irq_n` are 1 and both read-data outputs are 0.
- R2: An access with en=1 and we=1 is a write of the word at `addr`. An access with en=1, we=0 and oe=1 is a read, and the word appears on that port's rdata one clock after the read. rdata holds its value in cycles with no read.
- R3: The two mailbox words, at addresses 2^ADDR_W-2 and 2^ADDR_W-1, store and return data exactly like every other word, whatever state the flags are in.
- R4: A write by port B to address 2^ADDR_W-2 drives `a_irq_n` to 0 on the next clock. It stays at 0 until port A clears it.
- R5: A read by port A of address 2^ADDR_W-2 sets `a_irq_n` back to 1 on the next clock.
- R6: A write by port A to address 2^ADDR_W-1 drives `b_irq_n` to 0 on the next clock. It stays at 0 until port B clears it.
- R7: A read by port B of address 2^ADDR_W-1 sets `b_irq_n` back to 1 on the next clock.
- R8: If one flag sees a set and a clear in the same cycle, the set wins and the flag is 0 after that clock.
- R9: No flag changes in response to any of the following:
  - a port writing its own mailbox;
  - a port reading its partner's mailbox;
  - an access with en=0;
  - an access with en=1, we=0 and oe=0.
- R10: When both ports write the same address in one cycle, the word keeps port A's data.
- R11: When one port reads a word that the other port writes in the same cycle, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write select |
| a_oe | input | 1 | Port A read strobe |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_irq_n | output | 1 | Interrupt toward port A, active low |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write select |
| b_oe | input | 1 | Port B read strobe |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_irq_n | output | 1 | Interrupt toward port B, active low |

## Verification
Two functions can land on one flag in the same cycle: the sender's mailbox write that raises the flag, and the receiver's mailbox read that lowers it. The bench provokes this by driving port B's write to A's mailbox and port A's read of that same word on one clock edge. It does this once with the flag idle and once with it already pending. It expects `a_irq_n` to be 0 afterwards in both cases. A lone read that follows must then return the flag to 1, and the read data must equal the message just written.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Decoded kind of one port's access in a cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Mailbox hits produced by one port's decoder
    typedef struct packed {
        logic set_peer;   // this port wrote the partner's mailbox
        logic clr_own;    // this port read its own mailbox
    } mbx_hit_t;

    // A write takes precedence over the read strobe
    function automatic acc_e classify(input logic en, input logic we, input logic oe);
        if (!en)
            return ACC_IDLE;
        if (we)
            return ACC_WRITE;
        if (oe)
            return ACC_READ;
        return ACC_IDLE;
    endfunction

    // Mailbox word: top word when top_word is set, else the word below it
    function automatic int unsigned box_addr(input int unsigned aw, input bit top_word);
        return (32'd1 << aw) - (top_word ? 32'd1 : 32'd2);
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]   OWN_BOX  = '0,
    parameter logic [ADDR_W-1:0]   PEER_BOX = '1
) (
    input  logic              en,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr,
    output logic              rd,
    output mbx_hit_t          hit
);

    acc_e kind;

    always_comb begin
        kind         = classify(en, we, oe);
        wr           = (kind == ACC_WRITE);
        rd           = (kind == ACC_READ);
        hit.set_peer = wr && (addr == PEER_BOX);
        hit.clr_own  = rd && (addr == OWN_BOX);
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    logic pending;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (set)
            pending <= 1'b1;
        else if (clr)
            pending <= 1'b0;
    end

    assign irq_n = ~pending;

    // R4 R6 R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> !irq_n);

    // R5 R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> irq_n);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Port A is assigned last, so it wins a same-address collision (R10)
    always_ff @(posedge clk) begin
        if (b_wr)
            mem[b_addr] <= b_wdata;
        if (a_wr)
            mem[a_addr] <= a_wdata;
    end

    // Registered reads see the contents before this edge's writes (R11)
    always_ff @(posedge clk) begin
        if (rst) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_rd)
                a_rdata <= mem[a_addr];
            if (b_rd)
                b_rdata <= mem[b_addr];
        end
    end

    // R2
    rd_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
        !a_rd |=> $stable(a_rdata));

    // R2
    rd_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
        !b_rd |=> $stable(b_rdata));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic              a_oe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_en,
    input  logic              b_we,
    input  logic              b_oe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_A = ADDR_W'(box_addr(ADDR_W, 1'b0));
    localparam logic [ADDR_W-1:0] BOX_B = ADDR_W'(box_addr(ADDR_W, 1'b1));

    logic     a_wr, a_rd, b_wr, b_rd;
    mbx_hit_t hit_a, hit_b;

    mbx_decode #(.ADDR_W(ADDR_W), .OWN_BOX(BOX_A), .PEER_BOX(BOX_B)) u_dec_a (
        .en(a_en), .we(a_we), .oe(a_oe), .addr(a_addr),
        .wr(a_wr), .rd(a_rd), .hit(hit_a)
    );

    mbx_decode #(.ADDR_W(ADDR_W), .OWN_BOX(BOX_B), .PEER_BOX(BOX_A)) u_dec_b (
        .en(b_en), .we(b_we), .oe(b_oe), .addr(b_addr),
        .wr(b_wr), .rd(b_rd), .hit(hit_b)
    );

    mbx_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .rst(rst),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    // Flag toward A: set by B's write, cleared by A's read
    mbx_flag u_flag_a (
        .clk(clk), .rst(rst), .set(hit_b.set_peer), .clr(hit_a.clr_own), .irq_n(a_irq_n)
    );

    // Flag toward B: set by A's write, cleared by B's read
    mbx_flag u_flag_b (
        .clk(clk), .rst(rst), .set(hit_a.set_peer), .clr(hit_b.clr_own), .irq_n(b_irq_n)
    );

    // R1
    flags_reset_chk: assert property (@(posedge clk)
        rst |=> (a_irq_n && b_irq_n));

    // R9
    own_box_write_a_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we && a_addr == BOX_A && !(b_en && b_we && b_addr == BOX_A))
        |=> $stable(a_irq_n));

    // R9
    own_box_write_b_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_we && b_addr == BOX_B && !(a_en && a_we && a_addr == BOX_B))
        |=> $stable(b_irq_n));

endmodule

// File: tb/mbx_irq_ctrl_bench.sv
module mbx_irq_ctrl_bench;

    localparam int unsigned AW    = 4;
    localparam int unsigned DW    = 16;
    localparam int unsigned WORDS = 1 << AW;
    localparam logic [AW-1:0] BOXA = AW'(WORDS - 2);
    localparam logic [AW-1:0] BOXB = AW'(WORDS - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_en = 0, a_we = 0, a_oe = 0;
    logic b_en = 0, b_we = 0, b_oe = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_irq_n, b_irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [DW-1:0] model [WORDS];

    always #2 clk = ~clk;

    mbx_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_mbx_irq_ctrl (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_en(b_en), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drv_a(input logic en, we, oe, input logic [AW-1:0] ad, input logic [DW-1:0] d);
        a_en = en; a_we = we; a_oe = oe; a_addr = ad; a_wdata = d;
    endtask

    task automatic drv_b(input logic en, we, oe, input logic [AW-1:0] ad, input logic [DW-1:0] d);
        b_en = en; b_we = we; b_oe = oe; b_addr = ad; b_wdata = d;
    endtask

    task automatic idle();
        drv_a(0, 0, 0, '0, '0);
        drv_b(0, 0, 0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) step();
        check("R1 reset a_irq_n", a_irq_n, 1);
        check("R1 reset b_irq_n", b_irq_n, 1);
        check("R1 reset a_rdata", a_rdata, 0);
        rst = 1'b0;
        step();
        check("R1 post-reset a_irq_n", a_irq_n, 1);
        check("R1 post-reset b_irq_n", b_irq_n, 1);
        check("R1 post-reset b_rdata", b_rdata, 0);

        // Port A fills every word; its last write hits B's mailbox
        for (int k = 0; k < WORDS; k++) begin
            model[k] = DW'((k * 16'h1111) ^ 16'h5A5A);
            drv_a(1, 1, 1, AW'(k), model[k]);
            step();
            if (AW'(k) == BOXA)
                check("R9 own-box write a_irq_n", a_irq_n, 1);
        end
        idle();
        check("R6 b_irq_n after A write", b_irq_n, 0);
        check("R9 a_irq_n after A sweep", a_irq_n, 1);

        // Port B reads back every word
        for (int k = 0; k < WORDS; k++) begin
            drv_b(1, 0, 1, AW'(k), 16'hFFFF);
            step();
            check("R2 R3 B read data", b_rdata, model[k]);
            if (AW'(k) != BOXB)
                check("R9 b_irq_n held", b_irq_n, 0);
        end
        idle();
        check("R7 b_irq_n after B read", b_irq_n, 1);
        step();
        check("R2 b_rdata holds", b_rdata, model[WORDS-1]);

        // Port B fills every word; it hits A's mailbox and then its own
        for (int k = 0; k < WORDS; k++) begin
            model[k] = DW'(~(k * 16'h0F0F + 3));
            drv_b(1, 1, 0, AW'(k), model[k]);
            step();
            if (AW'(k) == BOXA)
                check("R4 a_irq_n after B write", a_irq_n, 0);
        end
        idle();
        check("R9 b_irq_n after own-box write", b_irq_n, 1);

        // Port A reads back every word
        for (int k = 0; k < WORDS; k++) begin
            drv_a(1, 0, 1, AW'(k), 16'h0);
            step();
            check("R2 R3 A read data", a_rdata, model[k]);
            if (AW'(k) < BOXA)
                check("R4 a_irq_n held", a_irq_n, 0);
            else
                check("R5 a_irq_n cleared", a_irq_n, 1);
        end
        idle();

        // Same-cycle set and clear on flag A: idle, then already pending
        for (int r = 0; r < 2; r++) begin
            drv_b(1, 1, 0, BOXA, DW'(16'hC0DE + r));
            drv_a(1, 0, 1, BOXA, 16'h0);
            step();
            idle();
            check("R8 a_irq_n set wins", a_irq_n, 0);
        end
        drv_a(1, 0, 1, BOXA, 16'h0);
        step();
        idle();
        check("R5 a_irq_n lone clear", a_irq_n, 1);
        check("R3 mailbox A message", a_rdata, 16'hC0DF);

        // Same-cycle set and clear on flag B
        drv_a(1, 1, 0, BOXB, 16'hBEEF);
        drv_b(1, 0, 1, BOXB, 16'h0);
        step();
        idle();
        check("R8 b_irq_n set wins", b_irq_n, 0);

        // Accesses that must leave flag B pending
        drv_a(0, 1, 1, BOXB, 16'h1234);  step(); idle();
        check("R9 disabled write b_irq_n", b_irq_n, 0);
        drv_b(1, 0, 0, BOXB, 16'h0);     step(); idle();
        check("R9 no-strobe read b_irq_n", b_irq_n, 0);
        drv_b(1, 0, 1, BOXA, 16'h0);     step(); idle();
        check("R9 partner-box read b_irq_n", b_irq_n, 0);
        drv_b(1, 0, 1, BOXB, 16'h0);     step(); idle();
        check("R7 b_irq_n final clear", b_irq_n, 1);
        check("R3 mailbox B message", b_rdata, 16'hBEEF);

        // Write collision on one address
        drv_a(1, 1, 0, AW'(3), 16'hAAAA);
        drv_b(1, 1, 0, AW'(3), 16'h5555);
        step(); idle();
        drv_b(1, 0, 1, AW'(3), 16'h0);
        step(); idle();
        check("R10 collision keeps A", b_rdata, 16'hAAAA);

        // Read during the other port's write returns old data
        drv_a(1, 1, 0, AW'(5), 16'h7777);
        drv_b(1, 0, 1, AW'(5), 16'h0);
        step(); idle();
        check("R11 read sees old data", b_rdata, model[5]);
        drv_b(1, 0, 1, AW'(5), 16'h0);
        step(); idle();
        check("R11 next read sees new data", b_rdata, 16'h7777);
        check("R9 flags idle at end", {a_irq_n, b_irq_n}, 2'b11);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule